// File: doc/BRIEF.md
# Virtualized supervisor timer-compare unit

This block keeps two 64-bit timer-compare registers for a hart that can host a guest operating system. One belongs to the supervisor. The other belongs to the guest and is compared against the time value shifted by a hypervisor offset. Software reaches both through a CSR-style access port. Each access carries an address, the current privilege level, a virtualization flag and a 32/64-bit mode flag. One cycle later the block returns read data, or one of two fault kinds: an illegal-instruction fault or a virtual-instruction fault.

The block re-evaluates each compare every cycle and drives one pending bit per register. It also merges the two pending bits into an interrupt-pending vector ahead of the enable mask. While the guest is running, accesses aimed at the supervisor compare addresses are steered to the guest register. This lets an unmodified guest kernel program its own timer without the hypervisor stepping in. In 32-bit mode each register is written as two halves. A new value only becomes the active compare value once both halves have arrived.

Top module: `vtcmp_unit`

## Requirements
- R1: While rst_n is low, rsp_valid, rsp_illegal, rsp_virtual, stip, vstip and irq_pending are 0. Both compare registers (staged and active) and both half-written flag pairs reset to 0.
- R2: Address map: supervisor compare is 0x14D for the low or full word and 0x15D for the high half; guest compare is 0x24D for the low or full word and 0x25D for the high half. Each access gets a response on rsp_* exactly one cycle after csr_valid. Read data depends on mode and address. In 32-bit mode (xlen32=1), a low-address read returns bits 31:0 zero-extended and a high-address read returns bits 63:32 zero-extended. In 64-bit mode a low-address read returns all 64 bits, and any high-address access raises an illegal fault ahead of every other check. Writes return 0. An unlisted address returns 0 with no fault.
- R3: An access to a listed address raises an illegal fault in every privilege level when ext_en=0 or time_present=0.
- R4: With ext_en=1 and time_present=1, a machine-level access (csr_priv=2'b11) never faults, whatever the enable bits are.
- R5: Below machine level (csr_priv 2'b00 or 2'b01), an access raises an illegal fault unless both mcnt_tm and menv_stce are 1. This check takes priority over the R6 check.
- R6: If the R5 check passes, a virtual fault is raised unless both hcnt_tm and henv_stce are 1. The R6 check applies to the guest addresses, and to the supervisor addresses while virt_on=1. rsp_illegal and rsp_virtual are never both 1.
- R7: With virt_on=1, reads and writes to 0x14D/0x15D act on the guest register, and the supervisor register is left unchanged.
- R8: In 32-bit mode a half write updates only that half of the staged value and sets that half's flag. The active compare value is loaded from the staged value only when both flags are set, and both flags then clear. The two halves may arrive in either order.
- R9: In 64-bit mode a write replaces the staged and active values with all 64 bits at once and clears both flags.
- R10: Each cycle, vstip is registered from (time_now + htime_delta, taken modulo 2^64) >= the guest active value, as an unsigned compare. stip is registered from time_now >= the supervisor active value. Each is due one cycle after its operands change.
- R11: irq_pending = (mip_sw | pend) & mie, where pend has stip at bit 5 and vstip at bit 6. A 0 in mip_sw bit 6 cannot clear an asserted vstip.
- R12: A faulting access changes no register or flag and returns rsp_rdata = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_valid | input | 1 | Access request this cycle |
| csr_write | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 64 | Write data (bits 31:0 used in 32-bit mode) |
| csr_priv | input | 2 | Privilege: 11 machine, 01 supervisor, 00 user |
| virt_on | input | 1 | Guest is running |
| xlen32 | input | 1 | 1 = 32-bit register mode |
| ext_en | input | 1 | Timer-compare extension enabled |
| time_present | input | 1 | A time source exists |
| mcnt_tm | input | 1 | Machine counter-enable time bit |
| menv_stce | input | 1 | Machine env-config compare enable |
| hcnt_tm | input | 1 | Hypervisor counter-enable time bit |
| henv_stce | input | 1 | Hypervisor env-config compare enable |
| time_now | input | 64 | Free-running time |
| htime_delta | input | 64 | Guest time offset |
| mip_sw | input | IRQ_W | Software-held pending bits |
| mie | input | IRQ_W | Interrupt enable mask |
| rsp_valid | output | 1 | Response valid |
| rsp_rdata | output | 64 | Read data |
| rsp_illegal | output | 1 | Illegal-instruction fault |
| rsp_virtual | output | 1 | Virtual-instruction fault |
| stip | output | 1 | Supervisor timer pending |
| vstip | output | 1 | Guest timer pending |
| irq_pending | output | IRQ_W | Masked pending vector |

## Verification
An access is sampled at one rising edge, and its response sits on rsp_* from that edge on. The scoreboard therefore pushes the expected response while the request is being driven and pops it at the falling edge that follows. A write that arms a compare loads the active value at the capture edge, and the pending bit follows at the next edge. Pending checks are therefore taken two falling edges after the write. Because the compare runs continuously, a later sample gives the same value. irq_pending is combinational from the pending bits and the vectors, so it is checked at the first falling edge after those change.

// File: rtl/vtcmp_pkg.sv
package vtcmp_pkg;
  localparam int unsigned TW = 64;
  localparam int unsigned HW = TW / 2;
  localparam logic [11:0] A_SUP_LO = 12'h14D;
  localparam logic [11:0] A_SUP_HI = 12'h15D;
  localparam logic [11:0] A_GST_LO = 12'h24D;
  localparam logic [11:0] A_GST_HI = 12'h25D;
  localparam logic [1:0]  PRIV_M   = 2'b11;
  localparam int unsigned BIT_STIP  = 5;
  localparam int unsigned BIT_VSTIP = 6;
  localparam int unsigned NSLOT     = 2;

  typedef enum logic [1:0] {TGT_NONE, TGT_SUP, TGT_GST} tgt_e;
  typedef enum logic [1:0] {FLT_NONE, FLT_ILLEGAL, FLT_VIRTUAL} flt_e;

  function automatic logic [TW-1:0] offset_time(input logic [TW-1:0] t,
                                                input logic [TW-1:0] d);
    return t + d;
  endfunction

  function automatic logic reached(input logic [TW-1:0] now,
                                   input logic [TW-1:0] cmp);
    return now >= cmp;
  endfunction

  function automatic logic [TW-1:0] put_half(input logic [TW-1:0] old,
                                             input logic [HW-1:0] w,
                                             input logic hi);
    return hi ? {w, old[HW-1:0]} : {old[TW-1:HW], w};
  endfunction
endpackage

// File: rtl/vtcmp_decode.sv
module vtcmp_decode
  import vtcmp_pkg::*;
(
  input  logic [11:0] addr,
  input  logic        virt,
  input  logic        xlen32,
  output tgt_e        tgt,
  output logic        hi,
  output logic        need_hyp,
  output logic        bad_width
);
  always_comb begin
    tgt      = TGT_NONE;
    hi       = 1'b0;
    need_hyp = 1'b0;
    unique case (addr)
      A_SUP_LO, A_SUP_HI: begin
        tgt      = virt ? TGT_GST : TGT_SUP;
        need_hyp = virt;
        hi       = (addr == A_SUP_HI);
      end
      A_GST_LO, A_GST_HI: begin
        tgt      = TGT_GST;
        need_hyp = 1'b1;
        hi       = (addr == A_GST_HI);
      end
      default: ;
    endcase
    bad_width = (tgt != TGT_NONE) && hi && !xlen32;
  end
endmodule

// File: rtl/vtcmp_gate.sv
module vtcmp_gate
  import vtcmp_pkg::*;
(
  input  logic [1:0] priv,
  input  logic       ext_en,
  input  logic       time_present,
  input  logic       m_tm,
  input  logic       m_stce,
  input  logic       h_tm,
  input  logic       h_stce,
  input  logic       need_hyp,
  output flt_e       flt
);
  always_comb begin
    if (!ext_en || !time_present)         flt = FLT_ILLEGAL;
    else if (priv == PRIV_M)              flt = FLT_NONE;
    else if (!(m_tm && m_stce))           flt = FLT_ILLEGAL;
    else if (need_hyp && !(h_tm && h_stce)) flt = FLT_VIRTUAL;
    else                                  flt = FLT_NONE;
  end
endmodule

// File: rtl/vtcmp_slot.sv
module vtcmp_slot
  import vtcmp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_hi,
  input  logic          wr_rv32,
  input  logic [TW-1:0] wdata,
  input  logic [TW-1:0] now,
  output logic [TW-1:0] staged,
  output logic [TW-1:0] armed,
  output logic [1:0]    flags,
  output logic          pend
);
  logic [1:0]    half_bit;
  logic [TW-1:0] merged;
  logic          both_done;

  assign half_bit  = wr_hi ? 2'b10 : 2'b01;
  assign merged    = put_half(staged, wdata[HW-1:0], wr_hi);
  assign both_done = ((flags | half_bit) == 2'b11);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged <= '0;
      armed  <= '0;
      flags  <= '0;
      pend   <= 1'b0;
    end else begin
      pend <= reached(now, armed);
      if (wr_en) begin
        if (wr_rv32) begin
          staged <= merged;
          if (both_done) begin
            armed <= merged;
            flags <= 2'b00;
          end else begin
            flags <= flags | half_bit;
          end
        end else begin
          staged <= wdata;
          armed  <= wdata;
          flags  <= 2'b00;
        end
      end
    end
  end
endmodule

// File: rtl/vtcmp_unit.sv
module vtcmp_unit
  import vtcmp_pkg::*;
#(
  parameter int unsigned IRQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_valid,
  input  logic             csr_write,
  input  logic [11:0]      csr_addr,
  input  logic [TW-1:0]    csr_wdata,
  input  logic [1:0]       csr_priv,
  input  logic             virt_on,
  input  logic             xlen32,
  input  logic             ext_en,
  input  logic             time_present,
  input  logic             mcnt_tm,
  input  logic             menv_stce,
  input  logic             hcnt_tm,
  input  logic             henv_stce,
  input  logic [TW-1:0]    time_now,
  input  logic [TW-1:0]    htime_delta,
  input  logic [IRQ_W-1:0] mip_sw,
  input  logic [IRQ_W-1:0] mie,
  output logic             rsp_valid,
  output logic [TW-1:0]    rsp_rdata,
  output logic             rsp_illegal,
  output logic             rsp_virtual,
  output logic             stip,
  output logic             vstip,
  output logic [IRQ_W-1:0] irq_pending
);
  tgt_e tgt;
  logic hi, need_hyp, bad_width;
  flt_e gate_flt, acc_flt;

  vtcmp_decode u_dec (
    .addr(csr_addr), .virt(virt_on), .xlen32(xlen32),
    .tgt(tgt), .hi(hi), .need_hyp(need_hyp), .bad_width(bad_width)
  );

  vtcmp_gate u_gate (
    .priv(csr_priv), .ext_en(ext_en), .time_present(time_present),
    .m_tm(mcnt_tm), .m_stce(menv_stce), .h_tm(hcnt_tm), .h_stce(henv_stce),
    .need_hyp(need_hyp), .flt(gate_flt)
  );

  always_comb begin
    if (tgt == TGT_NONE) acc_flt = FLT_NONE;
    else if (bad_width)  acc_flt = FLT_ILLEGAL;
    else                 acc_flt = gate_flt;
  end

  // named events for the checker
  logic acc_fault, acc_ok;
  assign acc_fault = csr_valid && (acc_flt != FLT_NONE);
  assign acc_ok    = csr_valid && (tgt != TGT_NONE) && (acc_flt == FLT_NONE);

  logic [TW-1:0] gst_now;
  assign gst_now = offset_time(time_now, htime_delta);

  logic [TW-1:0] slot_val   [NSLOT];
  logic [TW-1:0] slot_armed [NSLOT];
  logic [1:0]    slot_flags [NSLOT];
  logic [NSLOT-1:0] slot_pend, slot_wr;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam tgt_e MY_TGT = (g == 0) ? TGT_SUP : TGT_GST;
    assign slot_wr[g] = acc_ok && csr_write && (tgt == MY_TGT);
    vtcmp_slot u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr_en(slot_wr[g]), .wr_hi(hi), .wr_rv32(xlen32), .wdata(csr_wdata),
      .now((g == 0) ? time_now : gst_now),
      .staged(slot_val[g]), .armed(slot_armed[g]), .flags(slot_flags[g]),
      .pend(slot_pend[g])
    );
  end

  logic [TW-1:0] sup_value, gst_value, sup_armed, gst_armed;
  logic [1:0]    gst_flags;
  logic          gst_wr;
  assign sup_value = slot_val[0];
  assign gst_value = slot_val[1];
  assign sup_armed = slot_armed[0];
  assign gst_armed = slot_armed[1];
  assign gst_flags = slot_flags[1];
  assign gst_wr    = slot_wr[1];

  logic [TW-1:0] rd_val, rd_word;
  always_comb begin
    rd_val = (tgt == TGT_GST) ? gst_value : sup_value;
    if (xlen32) rd_word = hi ? {{HW{1'b0}}, rd_val[TW-1:HW]} : {{HW{1'b0}}, rd_val[HW-1:0]};
    else        rd_word = rd_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_illegal <= 1'b0;
      rsp_virtual <= 1'b0;
    end else begin
      rsp_valid   <= csr_valid;
      rsp_illegal <= csr_valid && (acc_flt == FLT_ILLEGAL);
      rsp_virtual <= csr_valid && (acc_flt == FLT_VIRTUAL);
      rsp_rdata   <= (acc_ok && !csr_write) ? rd_word : '0;
    end
  end

  assign stip  = slot_pend[0];
  assign vstip = slot_pend[1];

  logic [IRQ_W-1:0] pend_vec;
  always_comb begin
    pend_vec            = '0;
    pend_vec[BIT_STIP]  = stip;
    pend_vec[BIT_VSTIP] = vstip;
  end
  assign irq_pending = (mip_sw | pend_vec) & mie;
endmodule

// File: rtl/vtcmp_unit_chk.sv
module vtcmp_unit_chk
  import vtcmp_pkg::*;
#(
  parameter int unsigned IRQ_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             csr_valid,
  input logic [11:0]      csr_addr,
  input logic [TW-1:0]    csr_wdata,
  input logic [1:0]       csr_priv,
  input logic             xlen32,
  input logic             ext_en,
  input logic             time_present,
  input logic             rsp_valid,
  input logic [TW-1:0]    rsp_rdata,
  input logic             rsp_illegal,
  input logic             rsp_virtual,
  input logic             vstip,
  input logic [IRQ_W-1:0] mie,
  input logic [IRQ_W-1:0] irq_pending,
  input logic             acc_fault,
  input logic             gst_wr,
  input logic [TW-1:0]    gst_value,
  input logic [TW-1:0]    sup_value,
  input logic [TW-1:0]    gst_armed,
  input logic [TW-1:0]    sup_armed,
  input logic [1:0]       gst_flags
);
  logic gst_addr;
  assign gst_addr = (csr_addr == A_GST_LO) || (csr_addr == A_GST_HI);

  a_r3_ext_off_faults: assert property (@(posedge clk) disable iff (!rst_n)
    csr_valid && gst_addr && (!ext_en || !time_present) |=> rsp_illegal);

  a_r4_machine_passes: assert property (@(posedge clk) disable iff (!rst_n)
    csr_valid && csr_addr == A_GST_LO && ext_en && time_present && csr_priv == PRIV_M
    |=> !rsp_illegal && !rsp_virtual);

  a_r6_one_fault_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_illegal && rsp_virtual));

  a_r12_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_illegal || rsp_virtual) |-> rsp_rdata == '0);

  a_r12_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault |=> $stable(gst_value) && $stable(sup_value) && $stable(gst_flags)
                  && $stable(gst_armed) && $stable(sup_armed));

  a_r9_full_write: assert property (@(posedge clk) disable iff (!rst_n)
    gst_wr && !xlen32 |=> gst_armed == $past(csr_wdata) && gst_flags == 2'b00);

  a_r8_first_half_holds: assert property (@(posedge clk) disable iff (!rst_n)
    gst_wr && xlen32 && gst_flags == 2'b00 |=> $stable(gst_armed));

  a_r11_pending_merge: assert property (@(posedge clk) disable iff (!rst_n)
    vstip && mie[BIT_VSTIP] |-> irq_pending[BIT_VSTIP]);
endmodule

bind vtcmp_unit vtcmp_unit_chk #(.IRQ_W(IRQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_addr(csr_addr),
  .csr_wdata(csr_wdata), .csr_priv(csr_priv), .xlen32(xlen32),
  .ext_en(ext_en), .time_present(time_present), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_illegal(rsp_illegal), .rsp_virtual(rsp_virtual),
  .vstip(vstip), .mie(mie), .irq_pending(irq_pending), .acc_fault(acc_fault),
  .gst_wr(gst_wr), .gst_value(gst_value), .sup_value(sup_value),
  .gst_armed(gst_armed), .sup_armed(sup_armed), .gst_flags(gst_flags)
);

// File: tb/vtcmp_unit_test.sv
module vtcmp_unit_test;
  localparam int IRQ_W = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic csr_valid = 0, csr_write = 0;
  logic [11:0] csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic [1:0]  csr_priv = 2'b11;
  logic virt_on = 0, xlen32 = 0, ext_en = 1, time_present = 1;
  logic mcnt_tm = 1, menv_stce = 1, hcnt_tm = 1, henv_stce = 1;
  logic [63:0] time_now = 64'd1000, htime_delta = '0;
  logic [IRQ_W-1:0] mip_sw = '0, mie = '1;
  logic rsp_valid, rsp_illegal, rsp_virtual, stip, vstip;
  logic [63:0] rsp_rdata;
  logic [IRQ_W-1:0] irq_pending;

  vtcmp_unit #(.IRQ_W(IRQ_W)) uut (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  typedef struct packed { logic [63:0] rd; logic ill; logic vf; } rsp_t;
  rsp_t  exp_q[$];
  string tag_q[$];

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: called at a falling edge, returns at the next one
  task automatic acc(input bit wr, input logic [11:0] a, input logic [63:0] d,
                     input logic [63:0] rd, input bit ill, input bit vf, input string tag);
    rsp_t e;
    e.rd = rd; e.ill = ill; e.vf = vf;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    csr_valid = 1; csr_write = wr; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_valid = 0; csr_write = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2: unexpected response, actual 1 expected 0");
      end else begin
        rsp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_rdata, e.rd, {t, " rdata"});
        check({63'b0, rsp_illegal}, {63'b0, e.ill}, {t, " illegal"});
        check({63'b0, rsp_virtual}, {63'b0, e.vf}, {t, " virtual"});
      end
    end
  end

  task automatic settle(); repeat (2) @(negedge clk); endtask

  task automatic pend(input bit es, input bit ev, input string tag);
    settle();
    check({63'b0, stip}, {63'b0, es}, {tag, " stip"});
    check({63'b0, vstip}, {63'b0, ev}, {tag, " vstip"});
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check({63'b0, rsp_valid}, 64'd0, "R1 rsp_valid");
    check({63'b0, stip}, 64'd0, "R1 stip");
    check({63'b0, vstip}, 64'd0, "R1 vstip");
    check({48'b0, irq_pending}, 64'd0, "R1 irq");
    rst_n = 1;
    pend(1, 1, "R1 zero compare after reset");
    acc(0, 12'h24D, 0, 64'd0, 0, 0, "R1 guest reads 0");

    // R9 / R10 supervisor full write
    acc(1, 12'h14D, 64'd2000, 0, 0, 0, "R9 sup write");
    acc(0, 12'h14D, 0, 64'd2000, 0, 0, "R9 sup read");
    pend(0, 1, "R10 sup not reached");

    // R10 guest with offset
    acc(1, 12'h24D, 64'd1500, 0, 0, 0, "R9 gst write");
    htime_delta = 64'd600;
    acc(0, 12'h24D, 0, 64'd1500, 0, 0, "R9 gst read");
    pend(0, 1, "R10 offset reaches");
    check({63'b0, irq_pending[6]}, 64'd1, "R11 bit6 pending");
    check({63'b0, irq_pending[5]}, 64'd0, "R11 bit5 clear");
    htime_delta = 64'd0;
    pend(0, 0, "R10 offset removed");
    htime_delta = 64'hFFFF_FFFF_FFFF_FC1D; // sum wraps to 5
    pend(0, 0, "R10 wrap modulo");
    htime_delta = 64'd500;
    pend(0, 1, "R10 equal counts as reached");
    htime_delta = 64'd0;

    // R8 split writes
    xlen32 = 1;
    acc(1, 12'h24D, 64'd100, 0, 0, 0, "R8 lo write");
    acc(0, 12'h24D, 0, 64'd100, 0, 0, "R8 staged lo read");
    pend(0, 0, "R8 one half keeps old compare");
    acc(1, 12'h25D, 64'd0, 0, 0, 0, "R8 hi write");
    pend(0, 1, "R8 both halves arm");
    acc(0, 12'h25D, 0, 64'd0, 0, 0, "R8 hi read");
    acc(1, 12'h24D, 64'd5000, 0, 0, 0, "R8 flags cleared lo");
    pend(0, 1, "R8 flags cleared, not armed yet");
    acc(1, 12'h25D, 64'd0, 0, 0, 0, "R8 second hi");
    pend(0, 0, "R8 rearmed to 5000");
    acc(1, 12'h15D, 64'd0, 0, 0, 0, "R8 sup hi first");
    pend(0, 0, "R8 sup hi first holds");
    acc(1, 12'h14D, 64'd500, 0, 0, 0, "R8 sup lo second");
    pend(1, 0, "R8 reverse order arms");

    // R7 redirect
    xlen32 = 0; virt_on = 1; csr_priv = 2'b01;
    acc(1, 12'h14D, 64'd7, 0, 0, 0, "R7 redirected write");
    acc(0, 12'h14D, 0, 64'd7, 0, 0, "R7 redirected read");
    pend(1, 1, "R7 guest compare moved");
    virt_on = 0; csr_priv = 2'b11;
    acc(0, 12'h14D, 0, 64'd500, 0, 0, "R7 sup untouched");
    acc(0, 12'h24D, 0, 64'd7, 0, 0, "R7 guest holds 7");

    // R5 / R6 / R12 faults
    csr_priv = 2'b01; menv_stce = 0;
    acc(0, 12'h24D, 0, 0, 1, 0, "R5 illegal read");
    acc(1, 12'h24D, 64'd999, 0, 1, 0, "R12 illegal write");
    acc(0, 12'h14D, 0, 0, 1, 0, "R5 sup illegal");
    menv_stce = 1; henv_stce = 0;
    acc(0, 12'h24D, 0, 0, 0, 1, "R6 virtual read");
    acc(1, 12'h24D, 64'd888, 0, 0, 1, "R12 virtual write");
    acc(0, 12'h14D, 0, 64'd500, 0, 0, "R6 sup unvirtualized ok");
    virt_on = 1;
    acc(0, 12'h14D, 0, 0, 0, 1, "R6 redirected virtual");
    henv_stce = 1; hcnt_tm = 0;
    acc(0, 12'h14D, 0, 0, 0, 1, "R6 hcnt_tm off");
    virt_on = 0; mcnt_tm = 0; henv_stce = 0;
    acc(0, 12'h24D, 0, 0, 1, 0, "R5 priority over R6");
    csr_priv = 2'b00;
    acc(0, 12'h24D, 0, 0, 1, 0, "R5 user level");
    csr_priv = 2'b11;
    acc(0, 12'h24D, 0, 64'd7, 0, 0, "R4 machine ignores enables; R12 unchanged");
    mcnt_tm = 1; hcnt_tm = 1; henv_stce = 1;
    ext_en = 0;
    acc(0, 12'h24D, 0, 0, 1, 0, "R3 ext off");
    ext_en = 1; time_present = 0;
    acc(0, 12'h24D, 0, 0, 1, 0, "R3 no time");
    time_present = 1;
    acc(0, 12'h25D, 0, 0, 1, 0, "R2 hi in 64-bit mode");
    acc(0, 12'h300, 0, 0, 0, 0, "R2 unlisted address");
    pend(1, 1, "R12 compares unchanged");

    // R11 merge
    mie[6] = 0;
    @(negedge clk);
    check({63'b0, irq_pending[6]}, 64'd0, "R11 masked");
    mie[6] = 1; mip_sw[4] = 1;
    @(negedge clk);
    check({63'b0, irq_pending[6]}, 64'd1, "R11 sw 0 cannot clear");
    check({63'b0, irq_pending[4]}, 64'd1, "R11 sw bit passes");
    check({63'b0, irq_pending[5]}, 64'd1, "R11 stip bit5");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R2: missing responses, actual %0d expected 0", exp_q.size());
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule